// File: doc/BRIEF.md
# Training Pattern Match Qualifier

This block checks one receive lane during link training. For each deserialized word that arrives with its valid strobe, it compares the word with a programmable reference pattern. Only the bits that belong to the selected word size take part in the compare, so a single 12-bit datapath serves 8-, 10- and 12-bit links. Each compare gives a one-bit outcome: 1 when every compared bit agrees, 0 otherwise. The outcome is shifted into a history register.

The block does not report single outcomes. It raises a steady MATCH flag only after a full history of hits, and a steady MISMATCH flag only after a full history of misses. A training sequencer changes a lane delay, waits for new words, and then samples the two flags. Because the history restarts whenever the reference pattern or the word size changes, the flags always describe the configuration that is currently applied.

Top module: `pattern_run_qualifier`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, both `match_flag` and `mismatch_flag` are low.
- R2: Which bits are compared depends on `size_sel`. The value 2'b00 compares bits 7:0. The value 2'b01 compares bits 9:0. The values 2'b10 and 2'b11 compare bits 11:0. A difference in a bit outside the selected range has no effect on the outcome.
- R3: `match_flag` goes high after the clock edge that samples a valid word, when the last HIST_DEPTH valid outcomes (default 8) since the last clear are all hits.
- R4: `mismatch_flag` goes high after the clock edge that samples a valid word, when the last HIST_DEPTH valid outcomes since the last clear are all misses.
- R5: When the history holds both hits and misses, neither flag is high. A single miss lowers `match_flag` after the edge that samples it, and a single hit lowers `mismatch_flag` after the edge that samples it.
- R6: A cycle with `word_vld` low and no configuration change does not shift the history and leaves both flags unchanged.
- R7: Any change in the value of `ref_pattern` or `size_sel` empties the history and lowers both flags at the next edge. After that, a fresh run of HIST_DEPTH valid outcomes is needed before either flag can rise.
- R8: A valid word that arrives in the same cycle as a configuration change is discarded. It does not count toward the new history.
- R9: `match_flag` and `mismatch_flag` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word_vld | input | 1 | Strobe that marks `word_data` as a received word |
| word_data | input | 12 | Deserialized word, right-aligned |
| ref_pattern | input | 12 | Expected training word, right-aligned |
| size_sel | input | 2 | Word size select: 00 = 8 bits, 01 = 10 bits, 1x = 12 bits |
| match_flag | output | 1 | Full history of hits |
| mismatch_flag | output | 1 | Full history of misses |

## Verification
Two actions can fall in the same cycle: a configuration change that clears the history, and a valid word that would shift it. The bench provokes this both directly, by changing the word size together with a valid word, and at random, by changing the configuration while words keep streaming. In either case the clear must win: both flags go low, and the discarded word must not shorten the run of HIST_DEPTH outcomes that follows.

// File: rtl/prq_pkg.sv
`timescale 1ns/1ps
package prq_pkg;

  localparam int WORD_W = 12;
  localparam int NARROW_W = 8;
  localparam int MID_W = 10;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    SZ_NARROW = 2'b00,
    SZ_MID    = 2'b01,
    SZ_FULL   = 2'b10,
    SZ_FULL_X = 2'b11
  } size_e;

  // Mask of the bits that take part in the compare for a word size.
  function automatic word_t size_mask(input logic [1:0] sel);
    word_t m;
    unique case (sel)
      SZ_NARROW: m = word_t'((1 << NARROW_W) - 1);
      SZ_MID:    m = word_t'((1 << MID_W) - 1);
      default:   m = '1;
    endcase
    return m;
  endfunction

  // One outcome bit: 1 when every compared bit agrees.
  function automatic logic masked_equal(input word_t a, input word_t b,
                                        input logic [1:0] sel);
    return ((a ^ b) & size_mask(sel)) == '0;
  endfunction

endpackage

// File: rtl/prq_compare.sv
`timescale 1ns/1ps
module prq_compare
  import prq_pkg::*;
(
  input  word_t      word_data,
  input  word_t      ref_pattern,
  input  logic [1:0] size_sel,
  output logic       word_hit
);
  always_comb word_hit = masked_equal(word_data, ref_pattern, size_sel);
endmodule

// File: rtl/prq_cfg_watch.sv
`timescale 1ns/1ps
module prq_cfg_watch
  import prq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  word_t      ref_pattern,
  input  logic [1:0] size_sel,
  output logic       cfg_change
);
  word_t      ref_q;
  logic [1:0] size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_q  <= '0;
      size_q <= '0;
    end else begin
      ref_q  <= ref_pattern;
      size_q <= size_sel;
    end
  end

  always_comb cfg_change = (ref_pattern != ref_q) || (size_sel != size_q);
endmodule

// File: rtl/prq_history.sv
`timescale 1ns/1ps
module prq_history #(
  parameter int HIST_DEPTH = 8,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift_en,
  input  logic             outcome,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             match_flag,
  output logic             mismatch_flag
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HIST_DEPTH);

  logic [HIST_DEPTH-1:0] hist_q, hist_nx;
  logic [CNT_W-1:0]      cnt_q, cnt_nx;
  logic                  full_nx;

  always_comb begin
    hist_nx = {hist_q[HIST_DEPTH-2:0], outcome};
    cnt_nx  = (cnt_q == FULL) ? FULL : cnt_q + 1'b1;
    full_nx = (cnt_nx == FULL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hist_q        <= '0;
      cnt_q         <= '0;
      match_flag    <= 1'b0;
      mismatch_flag <= 1'b0;
    end else if (shift_en) begin
      hist_q        <= hist_nx;
      cnt_q         <= cnt_nx;
      match_flag    <= full_nx && (&hist_nx);
      mismatch_flag <= full_nx && !(|hist_nx);
    end
  end

  assign fill_cnt = cnt_q;

  initial begin
    if (HIST_DEPTH < 2) $error("HIST_DEPTH must be at least 2");
  end
endmodule

// File: rtl/pattern_run_qualifier.sv
`timescale 1ns/1ps
module pattern_run_qualifier
  import prq_pkg::*;
#(
  parameter int HIST_DEPTH = 8,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_vld,
  input  logic [11:0] word_data,
  input  logic [11:0] ref_pattern,
  input  logic [1:0]  size_sel,
  output logic        match_flag,
  output logic        mismatch_flag
);
  logic             word_hit;
  logic             cfg_change;
  logic             shift_en;
  logic [CNT_W-1:0] fill_cnt;

  prq_compare u_cmp (
    .word_data   (word_data),
    .ref_pattern (ref_pattern),
    .size_sel    (size_sel),
    .word_hit    (word_hit)
  );

  prq_cfg_watch u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .ref_pattern (ref_pattern),
    .size_sel    (size_sel),
    .cfg_change  (cfg_change)
  );

  // The clear takes precedence; a word that arrives with it is dropped.
  assign shift_en = word_vld && !cfg_change;

  prq_history #(.HIST_DEPTH(HIST_DEPTH)) u_hist (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear         (cfg_change),
    .shift_en      (shift_en),
    .outcome       (word_hit),
    .fill_cnt      (fill_cnt),
    .match_flag    (match_flag),
    .mismatch_flag (mismatch_flag)
  );
endmodule

// File: rtl/prq_checker.sv
`timescale 1ns/1ps
module prq_checker #(
  parameter int HIST_DEPTH = 8,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             word_vld,
  input logic             word_hit,
  input logic             cfg_change,
  input logic [CNT_W-1:0] fill_cnt,
  input logic             match_flag,
  input logic             mismatch_flag
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(HIST_DEPTH);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_flag && mismatch_flag));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_vld && !cfg_change) |=> ($stable(match_flag) && $stable(mismatch_flag)));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_change |=> (!match_flag && !mismatch_flag && fill_cnt == '0));

  p_miss_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !cfg_change && !word_hit) |=> !match_flag);

  p_hit_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld && !cfg_change && word_hit) |=> !mismatch_flag);

  p_full_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
    match_flag |-> fill_cnt == FULL);

  p_full_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch_flag |-> fill_cnt == FULL);
endmodule

bind pattern_run_qualifier prq_checker #(.HIST_DEPTH(HIST_DEPTH)) u_prq_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .word_vld      (word_vld),
  .word_hit      (word_hit),
  .cfg_change    (cfg_change),
  .fill_cnt      (fill_cnt),
  .match_flag    (match_flag),
  .mismatch_flag (mismatch_flag)
);

// File: tb/test_pattern_run_qualifier.sv
`timescale 1ns/1ps
module test_pattern_run_qualifier;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_vld = 1'b0;
  logic [11:0] word_data = '0;
  logic [11:0] ref_pattern = '0;
  logic [1:0]  size_sel = '0;
  logic        match_flag, mismatch_flag;

  int total = 0;
  int bad = 0;

  logic [7:0]  m_hist = '0;
  int          m_cnt = 0;
  logic        m_match = 1'b0, m_miss = 1'b0;
  logic [11:0] m_ref = '0;
  logic [1:0]  m_size = '0;

  always #2.5 clk = ~clk;

  pattern_run_qualifier i_pattern_run_qualifier (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_data(word_data),
    .ref_pattern(ref_pattern), .size_sel(size_sel),
    .match_flag(match_flag), .mismatch_flag(mismatch_flag)
  );

  function automatic logic [11:0] bench_mask(input logic [1:0] s);
    if (s == 2'b00) return 12'h0FF;
    if (s == 2'b01) return 12'h3FF;
    return 12'hFFF;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [11:0] d, input string tag);
    logic hit;
    word_vld  = v;
    word_data = d;
    @(posedge clk);
    if (ref_pattern != m_ref || size_sel != m_size) begin
      m_hist = '0; m_cnt = 0; m_match = 1'b0; m_miss = 1'b0;
    end else if (v) begin
      hit = ((d & bench_mask(size_sel)) == (ref_pattern & bench_mask(size_sel)));
      m_hist = {m_hist[6:0], hit};
      if (m_cnt < 8) m_cnt++;
      m_match = (m_cnt == 8) && (m_hist == 8'hFF);
      m_miss  = (m_cnt == 8) && (m_hist == 8'h00);
    end
    m_ref  = ref_pattern;
    m_size = size_sel;
    #1;
    chk(tag, match_flag, m_match);
    chk(tag, mismatch_flag, m_miss);
    chk("R9", match_flag && mismatch_flag, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mode;
    logic [11:0] noise;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", match_flag, 1'b0);
    chk("R1", mismatch_flag, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1", match_flag, 1'b0);
    chk("R1", mismatch_flag, 1'b0);

    ref_pattern = 12'hA5C; size_sel = 2'b10;
    step(1'b0, '0, "R7");
    for (int i = 0; i < 8; i++) step(1'b1, 12'hA5C, "R3");
    chk("R3", match_flag, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b0, 12'h000, "R6");
    chk("R6", match_flag, 1'b1);
    step(1'b1, 12'hA5D, "R5");
    chk("R5", match_flag, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b1, 12'h123, "R4");
    chk("R4", mismatch_flag, 1'b1);
    step(1'b1, 12'hA5C, "R5");
    chk("R5", mismatch_flag, 1'b0);

    size_sel = 2'b00;
    step(1'b0, '0, "R7");
    for (int i = 0; i < 8; i++) step(1'b1, 12'hA5C ^ 12'hF00, "R2");
    chk("R2", match_flag, 1'b1);

    size_sel = 2'b01;
    step(1'b1, 12'hA5C ^ 12'h400, "R8");
    chk("R8", match_flag, 1'b0);
    for (int i = 0; i < 7; i++) step(1'b1, 12'hA5C ^ 12'hC00, "R8");
    chk("R8", match_flag, 1'b0);
    step(1'b1, 12'hA5C ^ 12'hC00, "R2");
    chk("R2", match_flag, 1'b1);
    step(1'b1, 12'hA5C ^ 12'h200, "R2");
    chk("R2", match_flag, 1'b0);
    for (int i = 0; i < 8; i++) step(1'b1, 12'hA5C, "R3");
    ref_pattern = 12'h3C3;
    step(1'b0, '0, "R7");
    chk("R7", match_flag, 1'b0);

    for (int blk = 0; blk < 250; blk++) begin
      mode = $urandom_range(0, 2);
      if ($urandom_range(0, 9) == 0) begin
        ref_pattern = 12'($urandom);
        size_sel = 2'($urandom);
      end
      for (int k = 0; k < 12; k++) begin
        if (mode == 0) noise = 12'($urandom) & ~bench_mask(size_sel);
        else if (mode == 1) noise = 12'($urandom) | 12'h001;
        else noise = ($urandom_range(0, 1) == 0) ? 12'h000 : 12'h010;
        step($urandom_range(0, 4) != 0, ref_pattern ^ noise,
             (mode == 1) ? "R4" : "R3");
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule